// File: doc/BRIEF.md
# CAN Error Status and Interrupt Unit

This block keeps the error and status word of a CAN controller and raises its interrupt requests. Each cycle it registers a snapshot of the controller's condition: the receive error level, bus idle, the direction of the frame in progress and the fault confinement state. It also latches one-cycle error event pulses until software reads them. Three sticky interrupt flags record entry into bus off, any detected error, and a wake-up edge seen on the bus in low-power stop mode. Each flag drives a request only while its mask input is set.

Software reaches the unit through a small register port. Address 0 returns the status word. Address 1 holds a per-buffer interrupt enable mask, which gates the buffers' completion flags into a single buffer interrupt. A flag is cleared by a handshake: it must first be read as 1 and then written with 1. A soft reset clears the status word. The confinement field is refilled from the live fault state on the first clock after the soft reset is released, so a controller that is still bus off shows bus off again.

Top module: `can_err_status`

## Requirements
- R1: Status bit 0 (receive warning) is 1 one clock after the receive error count is 96 or more, and 0 one clock after it is below 96.
- R2: Status bit 1 (idle) and bit 2 (1 = transmitting, 0 = receiving) copy the idle and transmit inputs one clock later.
- R3: Status bits [4:3] (confinement) show 00 for error active, 01 for error passive and 10 for bus off (any input code with its upper bit set), one clock after the fault state input.
- R4: Status bit 13 (bus-off flag) sets on the clock after the fault state's upper bit goes from 0 to 1. It does not set when the fault state is already bus off as hard reset is released.
- R5: Status bits [11:6] latch the six error event pulses and hold them until a read of address 0, which clears them on the next clock unless a new pulse arrives. Status bit 12 (error flag) sets on any error pulse.
- R6: Status bit 14 (wake flag) sets when the bus level goes from 1 (recessive) to 0 (dominant) while low-power stop is asserted. It never sets outside stop mode.
- R7: A flag clears only when a write to address 0 carries a 1 in that flag's bit and a read of address 0 returned that flag as 1 earlier. Writing 0, or writing 1 with no earlier read, leaves the flag set.
- R8: When a flag's setting event arrives in the same cycle as a clearing write, the flag stays set.
- R9: Each of the bus-off, error and wake requests equals its flag ANDed with its mask input.
- R10: While soft reset is high, the whole status word reads 0 and register writes and reads have no effect. On the first clock after release, the confinement field again shows the live fault state (10 if still bus off), without setting the bus-off flag.
- R11: Address 1 is a read/write per-buffer mask. The buffer request is 1 when any buffer has both its completion flag and its mask bit set.
- R12: After hard reset the status word, the mask register and all four requests are 0. Addresses other than 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_cnt | input | 8 | Receive error counter value |
| fault_state | input | 2 | Confinement state: 00 active, 01 passive, 1x bus off |
| bus_idle | input | 1 | Bus is idle |
| bus_tx | input | 1 | Controller is transmitting |
| err_evt | input | 6 | One-cycle error event pulses |
| low_power_stop | input | 1 | Controller is in low-power stop mode |
| bus_level | input | 1 | Sampled bus level, 1 recessive |
| mask_boff | input | 1 | Bus-off interrupt enable |
| mask_err | input | 1 | Error interrupt enable |
| mask_wake | input | 1 | Wake interrupt enable |
| soft_rst | input | 1 | Soft reset of the status word |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| buf_done | input | 16 | Per-buffer completion flags |
| status_word | output | 16 | Status word |
| irq_boff | output | 1 | Bus-off interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_wake | output | 1 | Wake interrupt request |
| irq_buf | output | 1 | Buffer interrupt request |

## Verification
Long random runs vary the error count, fault state, bus level, event pulses, masks and register traffic. These runs show whether the snapshot fields track their inputs, and whether flags clear only after the read-then-write-one handshake. Error counts of 95 and 96 pin down the warning threshold. Directed sequences separate four flag cases: a write of 1 with no earlier read, a write of 0 after a read, a proper clear, and a clear that collides with a new event. A soft reset applied during bus off shows that the confinement field is refilled from the fault state after release, while the bus-off flag stays clear.

// File: rtl/can_es_pkg.sv
package can_es_pkg;
  localparam int ST_W    = 16;
  localparam int NUM_ERR = 6;
  localparam int NUM_FLG = 3;

  localparam int P_WARN = 0;
  localparam int P_IDLE = 1;
  localparam int P_TXRX = 2;
  localparam int P_CONF = 3;
  localparam int P_ERRB = 6;
  localparam int P_FLG  = 12;

  localparam int F_ERR  = 0;
  localparam int F_BOFF = 1;
  localparam int F_WAKE = 2;

  typedef enum logic [1:0] {
    CONF_ACTIVE  = 2'b00,
    CONF_PASSIVE = 2'b01,
    CONF_BUSOFF  = 2'b10
  } conf_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
endpackage

// File: rtl/can_es_flag.sv
module can_es_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic set_evt,
  input  logic rd_seen,
  input  logic wr_one,
  output logic flag_o
);
  logic flag_q, flag_n;
  logic arm_q, arm_n;

  always_comb begin
    if (soft_clr) begin
      flag_n = 1'b0;
      arm_n  = 1'b0;
    end else begin
      flag_n = (flag_q & ~(wr_one & arm_q)) | set_evt;
      arm_n  = (rd_seen ? flag_q : arm_q) & flag_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag_o = flag_q;

  // R7: with no write of one the flag cannot drop
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !soft_clr && !wr_one |=> flag_q);
  // R7: a clear needs an earlier read of the set flag
  a_r7_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !arm_q && !soft_clr |=> flag_q);
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && !soft_clr |=> flag_q);
  // R10
  a_r10_soft_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !flag_q && !arm_q);
endmodule

// File: rtl/can_es_snap.sv
module can_es_snap #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int NUM_ERR    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic [CNT_W-1:0]   rx_cnt,
  input  logic [1:0]         fault,
  input  logic               idle_i,
  input  logic               tx_i,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               rd_clr,
  output logic               warn_q,
  output logic               idle_q,
  output logic               tx_q,
  output logic [1:0]         conf_q,
  output logic [NUM_ERR-1:0] errb_q
);
  import can_es_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARN_LIMIT);

  logic               warn_n, idle_n, tx_n;
  logic [1:0]         conf_n;
  logic [NUM_ERR-1:0] errb_n;

  always_comb begin
    if (soft_clr) begin
      warn_n = 1'b0;
      idle_n = 1'b0;
      tx_n   = 1'b0;
      conf_n = CONF_ACTIVE;
      errb_n = '0;
    end else begin
      warn_n = (rx_cnt >= LIMIT);
      idle_n = idle_i;
      tx_n   = tx_i;
      conf_n = fault[1] ? CONF_BUSOFF : fault;
      errb_n = (rd_clr ? '0 : errb_q) | err_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      idle_q <= 1'b0;
      tx_q   <= 1'b0;
      conf_q <= CONF_ACTIVE;
      errb_q <= '0;
    end else begin
      warn_q <= warn_n;
      idle_q <= idle_n;
      tx_q   <= tx_n;
      conf_q <= conf_n;
      errb_q <= errb_n;
    end
  end

  // R1
  a_r1_warn_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> warn_q == ($past(rx_cnt) >= LIMIT));
  // R3
  a_r3_busoff_code: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr && fault[1] |=> conf_q == 2'b10);
  // R5
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr && !rd_clr |=> (errb_q & $past(errb_q)) == $past(errb_q));
  // R10
  a_r10_soft_clears_snap: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> conf_q == 2'b00 && errb_q == '0 && !warn_q);
endmodule

// File: rtl/can_es_bufirq.sv
module can_es_bufirq #(
  parameter int NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic [NUM_BUF-1:0] done,
  output logic [NUM_BUF-1:0] mask_q,
  output logic               irq_o
);
  logic [NUM_BUF-1:0] mask_n;
  logic [NUM_BUF-1:0] hit;

  always_comb begin
    mask_n = wr_en ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_gate
    assign hit[i] = done[i] & mask_q[i];
  end

  assign irq_o = |hit;

  // R11
  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mask_q == $past(wdata));
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/can_err_status.sv
module can_err_status #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int NUM_BUF    = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [1:0]        fault_state,
  input  logic              bus_idle,
  input  logic              bus_tx,
  input  logic [5:0]        err_evt,
  input  logic              low_power_stop,
  input  logic              bus_level,
  input  logic              mask_boff,
  input  logic              mask_err,
  input  logic              mask_wake,
  input  logic              soft_rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_BUF-1:0] buf_done,
  output logic [DATA_W-1:0] status_word,
  output logic              irq_boff,
  output logic              irq_err,
  output logic              irq_wake,
  output logic              irq_buf
);
  import can_es_pkg::*;

  logic acc_ok, rd_stat, wr_stat, wr_mask;
  logic bprev_q, bprev_n, lvl_q, lvl_n;
  logic [NUM_FLG-1:0] flg_set, flg_q;
  logic warn_q, idle_q, tx_q;
  logic [1:0] conf_q;
  logic [NUM_ERR-1:0] errb_q;
  logic [NUM_BUF-1:0] mask_q;

  assign acc_ok  = ~soft_rst;
  assign rd_stat = acc_ok & reg_rd & (reg_addr == ADDR_STATUS);
  assign wr_stat = acc_ok & reg_wr & (reg_addr == ADDR_STATUS);
  assign wr_mask = acc_ok & reg_wr & (reg_addr == ADDR_MASK);

  // edge history, cleared by hard reset only
  always_comb begin
    bprev_n = fault_state[1];
    lvl_n   = bus_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bprev_q <= 1'b1;
      lvl_q   <= 1'b1;
    end else begin
      bprev_q <= bprev_n;
      lvl_q   <= lvl_n;
    end
  end

  always_comb begin
    flg_set         = '0;
    flg_set[F_ERR]  = acc_ok & (|err_evt);
    flg_set[F_BOFF] = acc_ok & fault_state[1] & ~bprev_q;
    flg_set[F_WAKE] = acc_ok & low_power_stop & lvl_q & ~bus_level;
  end

  can_es_snap #(
    .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT), .NUM_ERR(NUM_ERR)
  ) i_snap (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .rx_cnt(rx_err_cnt), .fault(fault_state),
    .idle_i(bus_idle), .tx_i(bus_tx), .err_evt(err_evt),
    .rd_clr(rd_stat),
    .warn_q(warn_q), .idle_q(idle_q), .tx_q(tx_q),
    .conf_q(conf_q), .errb_q(errb_q)
  );

  for (genvar f = 0; f < NUM_FLG; f++) begin : g_flag
    can_es_flag i_flag (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .set_evt(flg_set[f]), .rd_seen(rd_stat),
      .wr_one(wr_stat & reg_wdata[P_FLG+f]),
      .flag_o(flg_q[f])
    );
  end

  can_es_bufirq #(.NUM_BUF(NUM_BUF)) i_bufirq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask),
    .wdata(reg_wdata[NUM_BUF-1:0]), .done(buf_done),
    .mask_q(mask_q), .irq_o(irq_buf)
  );

  always_comb begin
    status_word = '0;
    status_word[P_WARN]                = warn_q;
    status_word[P_IDLE]                = idle_q;
    status_word[P_TXRX]                = tx_q;
    status_word[P_CONF +: 2]           = conf_q;
    status_word[P_ERRB +: NUM_ERR]     = errb_q;
    status_word[P_FLG +: NUM_FLG]      = flg_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STATUS: reg_rdata = status_word;
      ADDR_MASK:   reg_rdata[NUM_BUF-1:0] = mask_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_boff = flg_q[F_BOFF] & mask_boff;
  assign irq_err  = flg_q[F_ERR]  & mask_err;
  assign irq_wake = flg_q[F_WAKE] & mask_wake;

  // R4
  a_r4_boff_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst && fault_state[1] && !bprev_q |=> status_word[P_FLG+F_BOFF]);
  // R6
  a_r6_wake_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power_stop && !soft_rst && !status_word[P_FLG+F_WAKE]
      |=> !status_word[P_FLG+F_WAKE]);
  // R10
  a_r10_busoff_returns: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) && !soft_rst && fault_state[1] |=> status_word[4:3] == 2'b10);
endmodule

// File: tb/test_can_err_status.sv
module test_can_err_status;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic [7:0]  cnt;
  logic [1:0]  fst;
  logic        idle, tx, stop, lvl, mb, me, mw, srst, rd, wr;
  logic [5:0]  evt;
  logic [1:0]  addr;
  logic [15:0] wdata, done;
  logic [15:0] rdata, sw;
  logic        ib, ie, iw, ibuf;

  can_err_status i_can_err_status (
    .clk(clk), .rst_n(rst_n), .rx_err_cnt(cnt), .fault_state(fst),
    .bus_idle(idle), .bus_tx(tx), .err_evt(evt), .low_power_stop(stop),
    .bus_level(lvl), .mask_boff(mb), .mask_err(me), .mask_wake(mw),
    .soft_rst(srst), .reg_addr(addr), .reg_rd(rd), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .buf_done(done),
    .status_word(sw), .irq_boff(ib), .irq_err(ie), .irq_wake(iw),
    .irq_buf(ibuf)
  );

  int unsigned n_checks = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic       m_warn, m_idle, m_tx;
  logic [1:0] m_conf;
  logic [5:0] m_errb;
  logic [2:0] m_flag, m_arm;   // 0 err, 1 busoff, 2 wake
  logic       m_bprev, m_lvl;
  logic [15:0] m_mask;

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = '0;
    s[0] = m_warn; s[1] = m_idle; s[2] = m_tx; s[4:3] = m_conf;
    s[11:6] = m_errb; s[14:12] = m_flag;
    return s;
  endfunction

  function automatic logic [15:0] exp_rdata();
    if (addr == 2'd0) return exp_status();
    if (addr == 2'd1) return m_mask;
    return 16'h0;
  endfunction

  task automatic compare_all();
    chk("R1", "warn", 32'(sw[0]), 32'(m_warn));
    chk("R2", "idle/txrx", 32'(sw[2:1]), 32'({m_tx, m_idle}));
    chk("R3", "conf", 32'(sw[4:3]), 32'(m_conf));
    chk("R5", "errbits/errflag", 32'({sw[12], sw[11:6]}), 32'({m_flag[0], m_errb}));
    chk("R4", "boff flag", 32'(sw[13]), 32'(m_flag[1]));
    chk("R6", "wake flag", 32'(sw[14]), 32'(m_flag[2]));
    chk("R12", "reserved bits", 32'({sw[15], sw[5]}), 32'h0);
    chk("R9", "irqs", 32'({ib, ie, iw}),
        32'({m_flag[1] & mb, m_flag[0] & me, m_flag[2] & mw}));
    chk("R11", "irq_buf", 32'(ibuf), 32'(|(done & m_mask)));
    chk("R7", "rdata", 32'(rdata), 32'(exp_rdata()));
  endtask

  task automatic model_next();
    logic rdst, wrst;
    logic [2:0] setv, nf, na;
    logic [15:0] nm;
    nm = m_mask;
    if (wr && addr == 2'd1 && !srst) nm = wdata;
    if (srst) begin
      m_warn = 0; m_idle = 0; m_tx = 0; m_conf = 2'b00; m_errb = '0;
      m_flag = '0; m_arm = '0;
    end else begin
      rdst = rd && addr == 2'd0;
      wrst = wr && addr == 2'd0;
      setv[0] = |evt;
      setv[1] = fst[1] & ~m_bprev;
      setv[2] = stop & m_lvl & ~lvl;
      for (int f = 0; f < 3; f++) begin
        nf[f] = (m_flag[f] & ~(wrst & wdata[12+f] & m_arm[f])) | setv[f];
        na[f] = (rdst ? m_flag[f] : m_arm[f]) & nf[f];
      end
      m_warn = (cnt >= 8'd96);
      m_idle = idle; m_tx = tx;
      m_conf = fst[1] ? 2'b10 : fst;
      m_errb = (rdst ? 6'h0 : m_errb) | evt;
      m_flag = nf; m_arm = na;
    end
    m_bprev = fst[1];
    m_lvl = lvl;
    m_mask = nm;
  endtask

  // called at a negedge with inputs already driven
  task automatic tick();
    #1;
    compare_all();
    model_next();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    evt = '0; rd = 0; wr = 0; addr = 0; wdata = '0; srst = 0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 0;
    cnt = 8'd0; fst = 2'b10; idle = 1; tx = 0; stop = 0; lvl = 1;
    mb = 1; me = 1; mw = 1; done = 16'hFFFF;
    idle_inputs();
    m_warn = 0; m_idle = 0; m_tx = 0; m_conf = 0; m_errb = 0;
    m_flag = 0; m_arm = 0; m_bprev = 1; m_lvl = 1; m_mask = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    #1;
    chk("R12", "status in reset", 32'(sw), 32'h0);
    chk("R12", "irqs in reset", 32'({ib, ie, iw, ibuf}), 32'h0);
    addr = 2'd1; #1;
    chk("R12", "mask in reset", 32'(rdata), 32'h0);
    addr = 2'd3; #1;
    chk("R12", "unused address", 32'(rdata), 32'h0);
    addr = 2'd0;
    @(negedge clk);
    rst_n = 1;
    tick(); tick();
    // R4: already bus off at reset release gives no flag
    chk("R4", "no boff flag out of reset", 32'(sw[13]), 32'h0);
    chk("R3", "bus off code", 32'(sw[4:3]), 32'h2);
    // R1 boundary
    fst = 2'b01; cnt = 8'd95; tick(); tick();
    chk("R1", "count 95", 32'(sw[0]), 32'h0);
    cnt = 8'd96; tick();
    chk("R1", "count 96", 32'(sw[0]), 32'h1);
    // R4 bus-off entry
    fst = 2'b11; tick();
    chk("R4", "boff flag on entry", 32'(sw[13]), 32'h1);
    chk("R9", "irq_boff", 32'(ib), 32'h1);
    // R7: write 1 without read keeps flag
    wr = 1; addr = 0; wdata = 16'hFFFF; tick(); idle_inputs(); tick();
    chk("R7", "unarmed write of one", 32'(sw[13]), 32'h1);
    // read, then write 0: no effect
    rd = 1; tick(); idle_inputs();
    wr = 1; wdata = 16'h0; tick(); idle_inputs(); tick();
    chk("R7", "write of zero", 32'(sw[13]), 32'h1);
    // write 1 after read clears
    wr = 1; wdata = 16'h2000; tick(); idle_inputs(); tick();
    chk("R7", "armed clear", 32'(sw[13]), 32'h0);
    // R8: event in same cycle as clear
    evt = 6'h04; tick(); idle_inputs();
    rd = 1; tick(); idle_inputs();
    chk("R5", "errbits cleared by read", 32'(sw[11:6]), 32'h0);
    wr = 1; wdata = 16'h1000; evt = 6'h01; tick(); idle_inputs(); tick();
    chk("R8", "event beats clear", 32'(sw[12]), 32'h1);
    // R6: wake only in stop mode
    stop = 0; lvl = 1; tick(); lvl = 0; tick(); tick();
    chk("R6", "no wake outside stop", 32'(sw[14]), 32'h0);
    stop = 1; lvl = 1; tick(); lvl = 0; tick();
    chk("R6", "wake in stop", 32'(sw[14]), 32'h1);
    stop = 0; lvl = 1;
    // R10: soft reset while bus off
    fst = 2'b10; tick();
    srst = 1; rd = 1; wr = 1; addr = 0; wdata = 16'hFFFF; tick(); tick();
    chk("R10", "status cleared in soft reset", 32'(sw), 32'h0);
    idle_inputs(); tick();
    chk("R10", "bus off shown after release", 32'(sw[4:3]), 32'h2);
    chk("R10", "no boff flag after release", 32'(sw[13]), 32'h0);
    // R11 mask register
    done = 16'h0010; wr = 1; addr = 1; wdata = 16'h0001; tick(); idle_inputs(); tick();
    chk("R11", "no matching buffer", 32'(ibuf), 32'h0);
    wr = 1; addr = 1; wdata = 16'h0010; tick(); idle_inputs();
    addr = 1; tick();
    chk("R11", "mask readback", 32'(rdata), 32'h0010);
    chk("R11", "matching buffer", 32'(ibuf), 32'h1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cnt = (($urandom % 4) == 0) ? 8'(90 + $urandom % 12) : 8'($urandom);
      if (($urandom % 20) == 0) fst = 2'($urandom);
      idle = 1'($urandom); tx = 1'($urandom);
      evt = (($urandom % 8) == 0) ? 6'($urandom) : 6'h0;
      if (($urandom % 30) == 0) stop = ~stop;
      if (($urandom % 3) == 0) lvl = ~lvl;
      mb = 1'($urandom); me = 1'($urandom); mw = 1'($urandom);
      srst = (($urandom % 100) == 0);
      rd = (($urandom % 4) == 0);
      wr = (($urandom % 4) == 0);
      addr = 2'($urandom);
      if (($urandom % 8) == 0) addr = 2'd3;
      wdata = (($urandom % 2) == 0) ? 16'hFFFF : 16'($urandom);
      done = 16'($urandom);
      tick();
    end
    idle_inputs();
    tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule